// File: doc/BRIEF.md
# SIMT Execution Mask Reconvergence Stack

This block keeps the execution mask of one SIMD wave and the divergence stack that lets the wave walk a structured control-flow graph one path at a time. Each bit of the mask enables one lane. The register file uses the mask to gate its writes, so a lane whose bit is clear sees no effect from any instruction issued while the bit stays clear.

The issue stage hands the block one mask-control operation at a time. The operation comes with a per-lane condition vector, already reduced to one bit per lane (1 means the lane's condition value is nonzero), and up to two instruction addresses. Four operations are supported: save the mask with a rejoin address, restore from the stack with a jump, narrow the mask by a condition, and a two-way branch. The branch saves the rejoin point, saves the other path only when some lane needs it, and goes straight to the other path when no lane takes the first. A redirect pulse with a target address tells fetch where to continue.

Each operation takes two clock cycles: an accept edge and a completion edge. A busy output covers the time between them. Pushing onto a full stack and popping from an empty one are reported through sticky error flags that only reset clears.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the mask is all ones, the stack is empty and not full, both error flags are low, busy is low and no redirect is signalled.
- R2: An operation is accepted on an edge where op_valid is high and busy is low. Busy is high for exactly the next cycle. Results (mask, stack, flags, redirect) change only on the following edge. An operation presented while busy is high is ignored.
- R3: Operation code 0 (save) stores the current mask together with op_addr on the stack. The mask is unchanged and no redirect is signalled.
- R4: Operation code 1 (restore) removes the top entry, loads its mask and signals redirect_valid for one cycle with redirect_pc equal to the entry's address.
- R5: Operation code 2 (narrow) with a nonzero result sets the mask to the current mask AND op_cond, where bit i belongs to lane i. Inactive lanes stay inactive and no redirect is signalled.
- R6: Operation code 2 whose result is all zeros instead behaves exactly like code 1 on the top entry.
- R7: Operation code 3 (branch), when both the taken mask (current AND op_cond) and the other mask (current AND NOT op_cond) are nonzero, pushes (current, op_addr) and then (other mask, op_else_addr). The mask becomes the taken mask and there is no redirect.
- R8: Operation code 3 with an all-zero other mask pushes only (current, op_addr) and sets the mask to the taken mask.
- R9: Operation code 3 with an all-zero taken mask pushes only (current, op_addr). The mask becomes the other mask and the block redirects to op_else_addr.
- R10: An operation that needs more free entries than remain (one for codes 0 and 3 in the cases of R8 and R9, two for R7) is dropped entirely and sets overflow_err, which stays set until reset. stack_full is high when DEPTH entries are held.
- R11: A pop (code 1, or code 2 with a zero result) on an empty stack sets underflow_err, which stays set until reset. It leaves the mask unchanged and signals no redirect.
- R12: On an 8-lane wave, saving, then narrowing by the condition lane_id & 1 (op_cond 8'hAA), gives the body mask 8'hAA. With lane 0 written leftmost this reads 01010101. Restoring afterwards returns the mask to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present |
| op_code | input | 2 | 0 save, 1 restore, 2 narrow, 3 branch |
| op_cond | input | LANES | Per-lane condition, bit i for lane i |
| op_addr | input | AW | Rejoin address for codes 0 and 3 |
| op_else_addr | input | AW | Other-path address for code 3 |
| busy | output | 1 | Operation in progress; new operations are refused |
| exec_mask | output | LANES | Current execution mask, bit i enables lane i |
| redirect_valid | output | 1 | One-cycle pulse: fetch must continue at redirect_pc |
| redirect_pc | output | AW | Redirect target |
| stack_empty | output | 1 | No entries held |
| stack_full | output | 1 | DEPTH entries held |
| overflow_err | output | 1 | Sticky: a push was dropped on a full stack |
| underflow_err | output | 1 | Sticky: a pop found the stack empty |

## Verification
The bench builds the block with 8 lanes, a stack depth of 4 and 16-bit addresses. Eight lanes let it run the odd-lane example and masks split into halves and quarters. A depth of 4 brings the full stack within four pushes, so the bench reaches the one-free-entry case, where a two-entry branch must be dropped but a fallback branch still fits. A mid-run reset clears the sticky flags, so overflow and underflow are each checked from a clean state.

// File: rtl/simt_pkg.sv
package simt_pkg;
    typedef enum logic [1:0] {
        OP_SAVE    = 2'd0,
        OP_RESTORE = 2'd1,
        OP_NARROW  = 2'd2,
        OP_BRANCH  = 2'd3
    } simt_op_e;
endpackage

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
    parameter int LANES = 8,
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPW-1:0]   sp,
    input  logic [1:0]       wr_cnt,
    input  logic [LANES-1:0] wr0_mask,
    input  logic [AW-1:0]    wr0_addr,
    input  logic [LANES-1:0] wr1_mask,
    input  logic [AW-1:0]    wr1_addr,
    output logic [LANES-1:0] top_mask,
    output logic [AW-1:0]    top_addr
);
    logic [LANES-1:0] ent_mask [DEPTH];
    logic [AW-1:0]    ent_addr [DEPTH];
    logic [SPW-1:0]   sp_up;

    assign sp_up = sp + SPW'(1);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_mask[g] <= '0;
                ent_addr[g] <= '0;
            end else if (wr_cnt != 2'd0 && sp == SPW'(g)) begin
                ent_mask[g] <= wr0_mask;
                ent_addr[g] <= wr0_addr;
            end else if (wr_cnt == 2'd2 && sp_up == SPW'(g)) begin
                ent_mask[g] <= wr1_mask;
                ent_addr[g] <= wr1_addr;
            end
        end
    end

    always_comb begin
        top_mask = ent_mask[0];
        top_addr = ent_addr[0];
        for (int i = 0; i < DEPTH; i++) begin
            if (sp == SPW'(i + 1)) begin
                top_mask = ent_mask[i];
                top_addr = ent_addr[i];
            end
        end
    end
endmodule

// File: rtl/simt_op_eval.sv
module simt_op_eval
    import simt_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  simt_op_e         op,
    input  logic [LANES-1:0] cond,
    input  logic [AW-1:0]    addr_a,
    input  logic [AW-1:0]    addr_b,
    input  logic [LANES-1:0] cur_mask,
    input  logic [SPW-1:0]   sp,
    input  logic [LANES-1:0] top_mask,
    input  logic [AW-1:0]    top_addr,
    output logic [1:0]       push_n,
    output logic             pop,
    output logic [LANES-1:0] nxt_mask,
    output logic             redir,
    output logic [AW-1:0]    rpc,
    output logic             set_ovf,
    output logic             set_unf,
    output logic [LANES-1:0] w0_mask,
    output logic [AW-1:0]    w0_addr,
    output logic [LANES-1:0] w1_mask,
    output logic [AW-1:0]    w1_addr
);
    logic [SPW-1:0]   room;
    logic [SPW-1:0]   need;
    logic [LANES-1:0] narrowed;
    logic [LANES-1:0] taken;
    logic [LANES-1:0] other;

    assign room     = SPW'(DEPTH) - sp;
    assign narrowed = cur_mask & cond;
    assign taken    = cur_mask & cond;
    assign other    = cur_mask & ~cond;
    assign need     = (taken != '0 && other != '0) ? SPW'(2) : SPW'(1);

    always_comb begin
        push_n   = 2'd0;
        pop      = 1'b0;
        nxt_mask = cur_mask;
        redir    = 1'b0;
        rpc      = top_addr;
        set_ovf  = 1'b0;
        set_unf  = 1'b0;
        w0_mask  = cur_mask;
        w0_addr  = addr_a;
        w1_mask  = other;
        w1_addr  = addr_b;
        unique case (op)
            OP_SAVE: begin
                if (room == '0) set_ovf = 1'b1;
                else            push_n  = 2'd1;
            end
            OP_RESTORE: begin
                if (sp == '0) begin
                    set_unf = 1'b1;
                end else begin
                    pop      = 1'b1;
                    nxt_mask = top_mask;
                    redir    = 1'b1;
                end
            end
            OP_NARROW: begin
                if (narrowed != '0) begin
                    nxt_mask = narrowed;
                end else if (sp == '0) begin
                    set_unf = 1'b1;
                end else begin
                    pop      = 1'b1;
                    nxt_mask = top_mask;
                    redir    = 1'b1;
                end
            end
            OP_BRANCH: begin
                if (need > room) begin
                    set_ovf = 1'b1;
                end else begin
                    push_n = need[1:0];
                    if (taken != '0) begin
                        nxt_mask = taken;
                    end else begin
                        nxt_mask = other;
                        redir    = 1'b1;
                        rpc      = addr_b;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [LANES-1:0] op_cond,
    input  logic [AW-1:0]    op_addr,
    input  logic [AW-1:0]    op_else_addr,
    output logic             busy,
    output logic [LANES-1:0] exec_mask,
    output logic             redirect_valid,
    output logic [AW-1:0]    redirect_pc,
    output logic             stack_empty,
    output logic             stack_full,
    output logic             overflow_err,
    output logic             underflow_err
);
    typedef struct packed {
        logic             busy;
        simt_op_e         op;
        logic [LANES-1:0] cond;
        logic [AW-1:0]    a;
        logic [AW-1:0]    b;
        logic [LANES-1:0] mask;
        logic [SPW-1:0]   sp;
        logic             ovf;
        logic             unf;
        logic             rv;
        logic [AW-1:0]    rpc;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0] top_mask, ev_mask, w0_mask, w1_mask;
    logic [AW-1:0]    top_addr, ev_rpc, w0_addr, w1_addr;
    logic [1:0]       ev_push, wr_cnt;
    logic             ev_pop, ev_redir, ev_ovf, ev_unf;

    simt_op_eval #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) u_eval (
        .op       (st_q.op),
        .cond     (st_q.cond),
        .addr_a   (st_q.a),
        .addr_b   (st_q.b),
        .cur_mask (st_q.mask),
        .sp       (st_q.sp),
        .top_mask (top_mask),
        .top_addr (top_addr),
        .push_n   (ev_push),
        .pop      (ev_pop),
        .nxt_mask (ev_mask),
        .redir    (ev_redir),
        .rpc      (ev_rpc),
        .set_ovf  (ev_ovf),
        .set_unf  (ev_unf),
        .w0_mask  (w0_mask),
        .w0_addr  (w0_addr),
        .w1_mask  (w1_mask),
        .w1_addr  (w1_addr)
    );

    assign wr_cnt = st_q.busy ? ev_push : 2'd0;

    simt_stack_store #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sp       (st_q.sp),
        .wr_cnt   (wr_cnt),
        .wr0_mask (w0_mask),
        .wr0_addr (w0_addr),
        .wr1_mask (w1_mask),
        .wr1_addr (w1_addr),
        .top_mask (top_mask),
        .top_addr (top_addr)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        if (!st_q.busy) begin
            if (op_valid) begin
                st_d.busy = 1'b1;
                st_d.op   = simt_op_e'(op_code);
                st_d.cond = op_cond;
                st_d.a    = op_addr;
                st_d.b    = op_else_addr;
            end
        end else begin
            st_d.busy = 1'b0;
            st_d.mask = ev_mask;
            st_d.sp   = st_q.sp + SPW'(ev_push) - SPW'(ev_pop);
            st_d.ovf  = st_q.ovf | ev_ovf;
            st_d.unf  = st_q.unf | ev_unf;
            st_d.rv   = ev_redir;
            if (ev_redir) st_d.rpc = ev_rpc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.op   <= OP_SAVE;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy           = st_q.busy;
    assign exec_mask      = st_q.mask;
    assign redirect_valid = st_q.rv;
    assign redirect_pc    = st_q.rpc;
    assign stack_empty    = (st_q.sp == '0);
    assign stack_full     = (st_q.sp == SPW'(DEPTH));
    assign overflow_err   = st_q.ovf;
    assign underflow_err  = st_q.unf;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
    parameter int LANES = 8,
    parameter int AW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             busy,
    input logic [LANES-1:0] exec_mask,
    input logic             redirect_valid,
    input logic [AW-1:0]    redirect_pc,
    input logic             stack_empty,
    input logic             stack_full,
    input logic             overflow_err,
    input logic             underflow_err
);
    // R2: accepted operation raises busy for one cycle only
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> busy);
    p_busy_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R2: mask moves only on a completion edge
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(exec_mask));
    // R4: redirect is a single-cycle pulse that follows a busy cycle
    p_redir_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);
    p_redir_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redirect_valid) |-> $past(busy));
    // R10: stack cannot be empty and full at once; overflow is sticky
    p_empty_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stack_empty && stack_full));
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);
    // R11: underflow is sticky and only raised from an empty stack
    p_unf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);
    p_unf_from_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow_err) |-> $past(stack_empty));

    logic unused_pc;
    assign unused_pc = ^redirect_pc;
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .busy           (busy),
    .exec_mask      (exec_mask),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .stack_empty    (stack_empty),
    .stack_full     (stack_full),
    .overflow_err   (overflow_err),
    .underflow_err  (underflow_err)
);

// File: tb/sim_simt_mask_stack.sv
module sim_simt_mask_stack;
    import simt_pkg::*;
    localparam int L = 8;
    localparam int D = 4;
    localparam int A = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [1:0] op_code = 2'd0;
    logic [L-1:0] op_cond = '0;
    logic [A-1:0] op_addr = '0, op_else_addr = '0;
    logic busy, redirect_valid, stack_empty, stack_full, overflow_err, underflow_err;
    logic [L-1:0] exec_mask;
    logic [A-1:0] redirect_pc;

    always #4 clk = ~clk;

    simt_mask_stack #(.LANES(L), .DEPTH(D), .AW(A)) u0 (.*);

    typedef struct {
        logic [L-1:0] mask;
        bit rv;
        logic [A-1:0] pc;
        bit emp, full, ovf, unf;
        string tag;
    } exp_t;
    exp_t sb[$];

    int n_chk = 0, n_bad = 0;
    logic [L-1:0] m_mask [D];
    logic [A-1:0] m_addr [D];
    int msp;
    logic [L-1:0] cmask;
    bit movf, munf;
    bit done = 0;

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        msp = 0; cmask = '1; movf = 0; munf = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "mask", exec_mask, 8'hFF);
        check("R1", "empty", stack_empty, 1);
        check("R1", "full", stack_full, 0);
        check("R1", "ovf", overflow_err, 0);
        check("R1", "unf", underflow_err, 0);
        check("R1", "busy", busy, 0);
        check("R1", "redirect", redirect_valid, 0);
    endtask

    // driver: computes expected result, queues it, drives one operation
    task automatic run_op(simt_op_e op, logic [L-1:0] c, logic [A-1:0] a,
                          logic [A-1:0] b, string tag, bit hold = 0);
        exp_t e;
        logic [L-1:0] t, o;
        int need;
        e.rv = 0; e.pc = '0;
        case (op)
            OP_SAVE: begin
                if (msp == D) movf = 1;
                else begin m_mask[msp] = cmask; m_addr[msp] = a; msp++; end
            end
            OP_RESTORE: begin
                if (msp == 0) munf = 1;
                else begin msp--; cmask = m_mask[msp]; e.rv = 1; e.pc = m_addr[msp]; end
            end
            OP_NARROW: begin
                t = cmask & c;
                if (t != '0) cmask = t;
                else if (msp == 0) munf = 1;
                else begin msp--; cmask = m_mask[msp]; e.rv = 1; e.pc = m_addr[msp]; end
            end
            default: begin
                t = cmask & c; o = cmask & ~c;
                need = (t != '0 && o != '0) ? 2 : 1;
                if (msp + need > D) movf = 1;
                else begin
                    m_mask[msp] = cmask; m_addr[msp] = a; msp++;
                    if (t != '0) begin
                        if (o != '0) begin m_mask[msp] = o; m_addr[msp] = b; msp++; end
                        cmask = t;
                    end else begin
                        cmask = o; e.rv = 1; e.pc = b;
                    end
                end
            end
        endcase
        e.mask = cmask; e.emp = (msp == 0); e.full = (msp == D);
        e.ovf = movf; e.unf = munf; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_cond = c; op_addr = a; op_else_addr = b;
        @(negedge clk);
        if (!hold) op_valid = 1'b0;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // monitor: compare on the cycle after each completion edge
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_busy && !busy) begin
            exp_t e;
            if (sb.size() == 0) begin
                check("R2", "unexpected completion", 1, 0);
            end else begin
                e = sb.pop_front();
                check(e.tag, "mask", exec_mask, e.mask);
                check(e.tag, "redirect_valid", redirect_valid, e.rv);
                if (e.rv) check(e.tag, "redirect_pc", redirect_pc, e.pc);
                check(e.tag, "empty", stack_empty, e.emp);
                check(e.tag, "full", stack_full, e.full);
                check(e.tag, "ovf", overflow_err, e.ovf);
                check(e.tag, "unf", underflow_err, e.unf);
            end
        end
        prev_busy = rst_n ? busy : 1'b0;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R12 odd-lane example
        run_op(OP_SAVE,    8'h00, 16'h0020, 16'h0, "R12 save");
        run_op(OP_NARROW,  8'hAA, 16'h0,    16'h0, "R12 body mask");
        run_op(OP_NARROW,  8'hFF, 16'h0,    16'h0, "R5 inactive stay off");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R12 reconverge");
        // R7 two-way branch
        run_op(OP_BRANCH,  8'h0F, 16'h0040, 16'h0030, "R7 both paths");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R4 to else");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R4 to converge");
        // R8 all taken
        run_op(OP_BRANCH,  8'hFF, 16'h0044, 16'h0034, "R8 all taken");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R4 after R8");
        // R9 none taken
        run_op(OP_BRANCH,  8'h00, 16'h0048, 16'h0038, "R9 fallback");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R4 after R9");
        // R5/R6 loop style narrowing
        run_op(OP_SAVE,    8'h00, 16'h0050, 16'h0, "R3 loop save");
        run_op(OP_NARROW,  8'h7F, 16'h0,    16'h0, "R5 narrow 7F");
        run_op(OP_NARROW,  8'h3C, 16'h0,    16'h0, "R5 narrow 3C");
        run_op(OP_NARROW,  8'hC3, 16'h0,    16'h0, "R6 zero pops");
        // R11 underflow
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R11 restore empty");
        run_op(OP_NARROW,  8'h00, 16'h0,    16'h0, "R11 narrow empty");
        run_op(OP_SAVE,    8'h00, 16'h0060, 16'h0, "R3 save after R11");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R11 flag sticky");
        // R10 overflow, R2 ignored-while-busy
        do_reset();
        run_op(OP_SAVE,    8'h00, 16'h0101, 16'h0, "R2 held save", 1);
        run_op(OP_SAVE,    8'h00, 16'h0102, 16'h0, "R3 save 2");
        run_op(OP_SAVE,    8'h00, 16'h0103, 16'h0, "R2 R3 save 3 not full");
        run_op(OP_BRANCH,  8'h0F, 16'h0104, 16'h0105, "R10 branch needs two");
        run_op(OP_BRANCH,  8'h00, 16'h0106, 16'h0107, "R9 R10 fallback fits");
        run_op(OP_SAVE,    8'h00, 16'h0108, 16'h0, "R10 save on full");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R4 pop 4");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R4 pop 3");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R4 pop 2");
        run_op(OP_RESTORE, 8'h00, 16'h0,    16'h0, "R4 pop 1");
        repeat (3) @(negedge clk);
        check("R2", "queue drained", sb.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule